// File: doc/BRIEF.md
# Impedance Measurement Sequencer

This block runs one complete calibrate-or-measure cycle on an impedance-converter device. The device sits behind a byte-level I2C master, and the sequencer drives that master through a command port. A single `go` strobe latches the requested configuration. The block then walks a fixed sequence of transactions:

1. Put the device in standby.
2. Program the start frequency and the settling count.
3. Issue initialize-with-start-frequency.
4. Wait a programmable dwell.
5. Issue start-sweep.
6. Poll the status register until the valid-data bit is set.
7. Fetch the real and imaginary result words with a pointer-based block read.

A `done` pulse ends every cycle, whether it succeeded or failed. `error` tells the two outcomes apart. The results keep their values until the next successful cycle.

The command port is a valid/ready stream:

- `cmd_valid` stays high, and `cmd_op`, `cmd_byte` and `cmd_nack` stay unchanged, until the master takes the command with `cmd_ready`.
- Only one command is outstanding at a time. The next command is not offered until the master returns a one-cycle `rsp_valid`.
- The response side has no back-pressure. The sequencer always takes a response in the cycle it arrives.

Command op codes are 0 = start (or repeated start), 1 = write byte, 2 = read byte, 3 = stop. The control byte written to register 0x80 is laid out as `{command[3:0], 0, range[1:0], gain1}`. The command nibble is 1011 for standby, 0001 for initialize and 0010 for start-sweep.

Top module: `imp_seq`

## Requirements
- R1: A `go` with `settle_mult` = 10 (the reserved code) issues no command. `done` pulses in the cycle after `go` is taken, with `error` = 1.
- R2: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_op`, `cmd_byte` and `cmd_nack` hold their values. No new command is offered until `rsp_valid` answers the previous one.
- R3: The setup stream is as follows. Ops are 0 = start, 1 = write, 2 = read, 3 = stop.
  - Start, write 0x1A, write 0x80, write the standby control byte.
  - Start, write 0x1A, write 0x82, then the three frequency bytes from the most significant down.
  - Start, write 0x1A, write 0x8A, write {00000, mult[1:0], count[8]}, write count[7:0].
  - Start, write 0x1A, write 0x80, write the initialize control byte, stop.
- R4: Every control byte equals {nibble, 0, range[1:0], gain1}. The nibble is 1011 for standby, 0001 for initialize and 0010 for sweep.
- R5: With `dwell_cycles` = D latched at `go`, the sweep start command is first offered D+1 cycles after the edge that takes the stop response of the initialize transaction.
- R6: After the dwell the sweep transaction is issued: start, write 0x1A, write 0x80, write the sweep control byte, stop. Then the poll transaction is issued: start, write 0x1A, write 0xB0, write 0x8F, start, write 0x1B, read with nack, stop. The poll repeats until bit 1 of the status byte is 1.
- R7: If POLL_MAX polls all return bit 1 clear, the cycle ends with `done` and `error` = 1, and no further command is issued.
- R8: The result fetch is: start, write 0x1A, write 0xB0, write 0x94, write 0xA1, write 0x04, start, write 0x1B, three reads with ack, one read with nack, stop. `res_real` = {byte0, byte1} and `res_imag` = {byte2, byte3}, both signed.
- R9: A write answered with `rsp_ack` = 0 is followed by exactly one stop command. The cycle then ends with `done` and `error` = 1.
- R10: `done` is a one-cycle pulse, and no command is offered while it is high. `res_real` and `res_imag` change only together with a successful `done`. `error` holds until the next accepted `go`, which clears it.
- R11: A `go` that arrives while a cycle is running is ignored. Configuration inputs changed after `go` do not alter the running stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Start strobe, taken when idle |
| freq_code | input | 24 | Start-frequency code |
| settle_cnt | input | 9 | Settling-cycle count |
| settle_mult | input | 2 | Settling multiplier: 00 = x1, 01 = x2, 11 = x4, 10 reserved |
| exc_range | input | 2 | Excitation range: 00 = 2 V, 01 = 200 mV, 10 = 400 mV, 11 = 1 V |
| gain1 | input | 1 | 1 = PGA gain 1, 0 = gain 5 |
| dwell_cycles | input | DWELL_W | Dwell after initialize, in cycles |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Master takes the command |
| cmd_op | output | 2 | 0 start, 1 write, 2 read, 3 stop |
| cmd_byte | output | 8 | Byte to write (0 for other ops) |
| cmd_nack | output | 1 | For a read: answer with nack |
| rsp_valid | input | 1 | Command completed (one cycle) |
| rsp_ack | input | 1 | Target acked the written byte |
| rsp_byte | input | 8 | Byte read |
| res_real | output | 16 | Signed real result |
| res_imag | output | 16 | Signed imaginary result |
| done | output | 1 | End-of-cycle pulse |
| error | output | 1 | Last cycle failed |

## Verification
The bench drives inputs and samples outputs on the falling edge. The first command appears on `cmd_valid` one edge after `go` is taken. Each later command appears one edge after the edge that takes the previous response, except for the sweep start. For the sweep start the bench counts D+2 falling-edge samples from the one where it raised the initialize stop response. The reserved-multiplier `done` is due at the first sample after `go`. Every other `done` is due one edge after the last response. `error` and the results are read in that same sample. The bench varies its response latency and throttles `cmd_ready`, so each check waits on the handshake rather than on a fixed count.

// File: rtl/imp_seq_pkg.sv
package imp_seq_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } bus_op_e;

  typedef struct packed {
    logic [23:0] freq;
    logic [8:0]  settle;
    logic [1:0]  mult;
    logic [1:0]  range;
    logic        gain1;
  } meas_cfg_t;

  localparam int STEP_W = 6;

  // step indices the sequencer branches on
  localparam logic [STEP_W-1:0] STEP_INIT_END   = 6'd19;
  localparam logic [STEP_W-1:0] STEP_SWEEP_BEG  = 6'd20;
  localparam logic [STEP_W-1:0] STEP_POLL_BEG   = 6'd25;
  localparam logic [STEP_W-1:0] STEP_POLL_END   = 6'd32;
  localparam logic [STEP_W-1:0] STEP_FETCH_BEG  = 6'd33;
  localparam logic [STEP_W-1:0] STEP_LAST       = 6'd45;

  localparam logic [7:0] DEV_WR     = 8'h1A;
  localparam logic [7:0] DEV_RD     = 8'h1B;
  localparam logic [7:0] REG_CTRL   = 8'h80;
  localparam logic [7:0] REG_FREQ   = 8'h82;
  localparam logic [7:0] REG_SETTLE = 8'h8A;
  localparam logic [7:0] REG_STAT   = 8'h8F;
  localparam logic [7:0] REG_RESULT = 8'h94;
  localparam logic [7:0] PTR_SET    = 8'hB0;
  localparam logic [7:0] BLK_READ   = 8'hA1;
  localparam logic [7:0] BLK_COUNT  = 8'h04;

  localparam logic [3:0] NIB_STANDBY = 4'hB;
  localparam logic [3:0] NIB_INIT    = 4'h1;
  localparam logic [3:0] NIB_SWEEP   = 4'h2;

  localparam logic [1:0] MULT_RESERVED = 2'b10;

endpackage

// File: rtl/imp_step_rom.sv
module imp_step_rom
  import imp_seq_pkg::*;
(
  input  logic [STEP_W-1:0] step,
  input  meas_cfg_t         cfg,
  output bus_op_e           op,
  output logic [7:0]        wbyte,
  output logic              nack
);

  function automatic logic [7:0] ctrl_byte(input logic [3:0] nib, input meas_cfg_t c);
    return {nib, 1'b0, c.range, c.gain1};
  endfunction

  always_comb begin
    op    = OP_STOP;
    wbyte = 8'h00;
    nack  = 1'b0;
    case (step)
      6'd0, 6'd4, 6'd10, 6'd15, 6'd20, 6'd25, 6'd29, 6'd33, 6'd39: op = OP_START;
      6'd1, 6'd5, 6'd11, 6'd16, 6'd21, 6'd26, 6'd34: begin op = OP_WRITE; wbyte = DEV_WR; end
      6'd30, 6'd40:               begin op = OP_WRITE; wbyte = DEV_RD; end
      6'd2, 6'd17, 6'd22:         begin op = OP_WRITE; wbyte = REG_CTRL; end
      6'd3:  begin op = OP_WRITE; wbyte = ctrl_byte(NIB_STANDBY, cfg); end
      6'd18: begin op = OP_WRITE; wbyte = ctrl_byte(NIB_INIT, cfg); end
      6'd23: begin op = OP_WRITE; wbyte = ctrl_byte(NIB_SWEEP, cfg); end
      6'd6:  begin op = OP_WRITE; wbyte = REG_FREQ; end
      6'd7:  begin op = OP_WRITE; wbyte = cfg.freq[23:16]; end
      6'd8:  begin op = OP_WRITE; wbyte = cfg.freq[15:8]; end
      6'd9:  begin op = OP_WRITE; wbyte = cfg.freq[7:0]; end
      6'd12: begin op = OP_WRITE; wbyte = REG_SETTLE; end
      6'd13: begin op = OP_WRITE; wbyte = {5'b00000, cfg.mult, cfg.settle[8]}; end
      6'd14: begin op = OP_WRITE; wbyte = cfg.settle[7:0]; end
      6'd27, 6'd35:               begin op = OP_WRITE; wbyte = PTR_SET; end
      6'd28: begin op = OP_WRITE; wbyte = REG_STAT; end
      6'd36: begin op = OP_WRITE; wbyte = REG_RESULT; end
      6'd37: begin op = OP_WRITE; wbyte = BLK_READ; end
      6'd38: begin op = OP_WRITE; wbyte = BLK_COUNT; end
      6'd31, 6'd44:               begin op = OP_READ; nack = 1'b1; end
      6'd41, 6'd42, 6'd43:        op = OP_READ;
      default: op = OP_STOP;
    endcase
  end

endmodule

// File: rtl/imp_downcnt.sv
module imp_downcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (load)                cnt_q <= load_val;
    else if (dec && cnt_q != '0)  cnt_q <= cnt_q - W'(1);
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/imp_byte_shift.sv
module imp_byte_shift #(
  parameter int LANES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shift,
  input  logic [7:0]           din,
  output logic [8*LANES-1:0]   dout
);

  logic [7:0] lane_q [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     lane_q[g] <= 8'h00;
      else if (shift) lane_q[g] <= (g == 0) ? din : lane_q[(g == 0) ? 0 : g-1];
    end
    assign dout[8*g +: 8] = lane_q[g];
  end

endmodule

// File: rtl/imp_seq.sv
module imp_seq
  import imp_seq_pkg::*;
#(
  parameter int POLL_MAX = 8,
  parameter int DWELL_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic [23:0]        freq_code,
  input  logic [8:0]         settle_cnt,
  input  logic [1:0]         settle_mult,
  input  logic [1:0]         exc_range,
  input  logic               gain1,
  input  logic [DWELL_W-1:0] dwell_cycles,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output logic [1:0]         cmd_op,
  output logic [7:0]         cmd_byte,
  output logic               cmd_nack,
  input  logic               rsp_valid,
  input  logic               rsp_ack,
  input  logic [7:0]         rsp_byte,
  output logic [15:0]        res_real,
  output logic [15:0]        res_imag,
  output logic               done,
  output logic               error
);

  localparam int POLL_W = $clog2(POLL_MAX + 1);
  localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(POLL_MAX - 1);

  typedef enum logic [2:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_DWELL, ST_FIN} seq_st_e;

  seq_st_e           st_q;
  logic [STEP_W-1:0] step_q;
  meas_cfg_t         cfg_q;
  logic [DWELL_W-1:0] dwell_q;
  logic [POLL_W-1:0] poll_q;
  logic              abort_q, err_q;
  logic [15:0]       re_q, im_q;

  bus_op_e    rom_op;
  logic [7:0] rom_byte;
  logic       rom_nack;
  logic       dwell_zero, dwell_load, take_rsp, shift_en;
  logic [31:0] rd_bytes;

  imp_step_rom u_rom (
    .step (step_q), .cfg (cfg_q),
    .op (rom_op), .wbyte (rom_byte), .nack (rom_nack)
  );

  assign take_rsp   = (st_q == ST_WAIT) && rsp_valid;
  assign dwell_load = take_rsp && !abort_q && (step_q == STEP_INIT_END);
  assign shift_en   = take_rsp && !abort_q && (rom_op == OP_READ);

  imp_downcnt #(.W(DWELL_W)) u_dwell (
    .clk (clk), .rst_n (rst_n), .load (dwell_load), .load_val (dwell_q),
    .dec (st_q == ST_DWELL), .zero (dwell_zero)
  );

  imp_byte_shift #(.LANES(4)) u_shift (
    .clk (clk), .rst_n (rst_n), .shift (shift_en), .din (rsp_byte), .dout (rd_bytes)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      step_q  <= '0;
      cfg_q   <= '0;
      dwell_q <= '0;
      poll_q  <= '0;
      abort_q <= 1'b0;
      err_q   <= 1'b0;
      re_q    <= '0;
      im_q    <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (go) begin
          if (settle_mult == MULT_RESERVED) begin
            err_q <= 1'b1;
            st_q  <= ST_FIN;
          end else begin
            cfg_q   <= '{freq: freq_code, settle: settle_cnt, mult: settle_mult,
                         range: exc_range, gain1: gain1};
            dwell_q <= dwell_cycles;
            err_q   <= 1'b0;
            abort_q <= 1'b0;
            poll_q  <= '0;
            step_q  <= '0;
            st_q    <= ST_ISSUE;
          end
        end
        ST_ISSUE: if (cmd_ready) st_q <= ST_WAIT;
        ST_WAIT: if (rsp_valid) begin
          if (abort_q) begin
            st_q <= ST_FIN;
          end else if (rom_op == OP_WRITE && !rsp_ack) begin
            abort_q <= 1'b1;
            err_q   <= 1'b1;
            st_q    <= ST_ISSUE;
          end else if (step_q == STEP_INIT_END) begin
            st_q <= ST_DWELL;
          end else if (step_q == STEP_POLL_END) begin
            // status byte is the most recent read, bit 1 = data valid
            if (rd_bytes[1]) begin
              step_q <= STEP_FETCH_BEG;
              st_q   <= ST_ISSUE;
            end else if (poll_q == POLL_LAST) begin
              err_q <= 1'b1;
              st_q  <= ST_FIN;
            end else begin
              poll_q <= poll_q + POLL_W'(1);
              step_q <= STEP_POLL_BEG;
              st_q   <= ST_ISSUE;
            end
          end else if (step_q == STEP_LAST) begin
            re_q <= rd_bytes[31:16];
            im_q <= rd_bytes[15:0];
            st_q <= ST_FIN;
          end else begin
            step_q <= step_q + STEP_W'(1);
            st_q   <= ST_ISSUE;
          end
        end
        ST_DWELL: if (dwell_zero) begin
          step_q <= STEP_SWEEP_BEG;
          st_q   <= ST_ISSUE;
        end
        ST_FIN:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_valid = (st_q == ST_ISSUE);
  assign cmd_op    = abort_q ? OP_STOP : rom_op;
  assign cmd_byte  = abort_q ? 8'h00 : rom_byte;
  assign cmd_nack  = abort_q ? 1'b0 : rom_nack;
  assign done      = (st_q == ST_FIN);
  assign error     = err_q;
  assign res_real  = re_q;
  assign res_imag  = im_q;

endmodule

// File: rtl/imp_seq_chk.sv
module imp_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [1:0]  cmd_op,
  input logic [7:0]  cmd_byte,
  input logic        cmd_nack,
  input logic [15:0] res_real,
  input logic [15:0] res_imag,
  input logic        done
);

  assert_cmd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_byte) && $stable(cmd_nack)));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cmd_valid);

  assert_result_update_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(res_real) || !$stable(res_imag)) |-> done);

  assert_nack_read_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op != 2'd2) |-> !cmd_nack);

endmodule

bind imp_seq imp_seq_chk u_chk (
  .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .cmd_ready (cmd_ready),
  .cmd_op (cmd_op), .cmd_byte (cmd_byte), .cmd_nack (cmd_nack),
  .res_real (res_real), .res_imag (res_imag), .done (done)
);

// File: tb/sim_imp_seq.sv
module sim_imp_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        go = 1'b0;
  logic [23:0] freq_code = '0;
  logic [8:0]  settle_cnt = '0;
  logic [1:0]  settle_mult = '0;
  logic [1:0]  exc_range = '0;
  logic        gain1 = 1'b0;
  logic [15:0] dwell_cycles = '0;
  logic        cmd_valid, cmd_nack, done, error;
  logic        cmd_ready = 1'b0;
  logic [1:0]  cmd_op;
  logic [7:0]  cmd_byte;
  logic        rsp_valid = 1'b0;
  logic        rsp_ack = 1'b0;
  logic [7:0]  rsp_byte = '0;
  logic [15:0] res_real, res_imag;

  imp_seq #(.POLL_MAX(4), .DWELL_W(16)) u0 (
    .clk, .rst_n, .go, .freq_code, .settle_cnt, .settle_mult, .exc_range, .gain1,
    .dwell_cycles, .cmd_valid, .cmd_ready, .cmd_op, .cmd_byte, .cmd_nack,
    .rsp_valid, .rsp_ack, .rsp_byte, .res_real, .res_imag, .done, .error
  );

  always #5 clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  logic [10:0] expq[$];
  logic [7:0]  rdq[$];
  bit  bp = 0;
  int  nack_at = -1;
  int  exp_dwell = 0;

  // model state
  bit  pending = 0, seen = 0, t0_ok = 0, stall = 0;
  int  lat = 0, pend_idx = 0, ncmd = 0, nwr = 0, t0 = 0;
  logic [1:0] st_op; logic [7:0] st_byte; logic st_nack;
  bit  pend_ack = 0; logic [7:0] pend_byte = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exv);
    end
  endtask

  task automatic push(input logic [1:0] op, input logic nk, input logic [7:0] b);
    expq.push_back({op, nk, b});
  endtask

  task automatic wr(input logic [7:0] b); push(2'd1, 1'b0, b); endtask

  function automatic logic [7:0] ctl(input logic [3:0] nib);
    return {nib, 1'b0, exc_range, gain1};
  endfunction

  task automatic exp_setup();
    push(0,0,0); wr(8'h1A); wr(8'h80); wr(ctl(4'hB));
    push(0,0,0); wr(8'h1A); wr(8'h82); wr(freq_code[23:16]); wr(freq_code[15:8]); wr(freq_code[7:0]);
    push(0,0,0); wr(8'h1A); wr(8'h8A); wr({5'b0, settle_mult, settle_cnt[8]}); wr(settle_cnt[7:0]);
    push(0,0,0); wr(8'h1A); wr(8'h80); wr(ctl(4'h1)); push(3,0,0);
  endtask

  task automatic exp_sweep();
    push(0,0,0); wr(8'h1A); wr(8'h80); wr(ctl(4'h2)); push(3,0,0);
  endtask

  task automatic exp_poll();
    push(0,0,0); wr(8'h1A); wr(8'hB0); wr(8'h8F); push(0,0,0); wr(8'h1B); push(2,1,0); push(3,0,0);
  endtask

  task automatic exp_fetch();
    push(0,0,0); wr(8'h1A); wr(8'hB0); wr(8'h94); wr(8'hA1); wr(8'h04);
    push(0,0,0); wr(8'h1B); push(2,0,0); push(2,0,0); push(2,0,0); push(2,1,0); push(3,0,0);
  endtask

  always @(posedge clk) cyc++;

  // behavioural I2C master / target model, evaluated each falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (stall)
        chk(cmd_valid && cmd_op == st_op && cmd_byte == st_byte && cmd_nack == st_nack,
            "R2 hold under back-pressure", {cmd_valid, cmd_op, cmd_byte}, {1'b1, st_op, st_byte});
      rsp_valid = 1'b0;
      if (pending) begin
        lat--;
        if (lat == 0) begin
          pending = 0; rsp_valid = 1'b1; rsp_ack = pend_ack; rsp_byte = pend_byte;
          if (pend_idx == 19) begin t0 = cyc; t0_ok = 1; end
        end
      end
      if (cmd_valid && !seen) begin
        seen = 1;
        if (ncmd == 20 && t0_ok)
          chk(cyc - t0 == exp_dwell + 2, "R5 dwell spacing", cyc - t0, exp_dwell + 2);
      end
      cmd_ready = cmd_valid && !pending && (!bp || (cyc % 3 != 0));
      stall = cmd_valid && !cmd_ready;
      st_op = cmd_op; st_byte = cmd_byte; st_nack = cmd_nack;
      if (cmd_valid && cmd_ready) begin
        if (expq.size() == 0) begin
          chk(0, "R1 R7 R9 R11 unexpected command", {cmd_op, cmd_byte}, 0);
        end else begin
          logic [10:0] e;
          e = expq.pop_front();
          chk(cmd_op == e[10:9] && (cmd_op != 2'd1 || cmd_byte == e[7:0]) &&
              (cmd_op != 2'd2 || cmd_nack == e[8]),
              "R3 R4 R6 R8 command stream", {cmd_op, cmd_nack, cmd_byte}, e);
        end
        pend_ack = 1'b1; pend_byte = 8'h00;
        if (cmd_op == 2'd1) begin
          if (nwr == nack_at) begin
            pend_ack = 1'b0;
            expq.delete();
            push(3,0,0);
          end
          nwr++;
        end
        if (cmd_op == 2'd2) pend_byte = (rdq.size() > 0) ? rdq.pop_front() : 8'h00;
        pending = 1; lat = 1 + (ncmd % 2); pend_idx = ncmd; ncmd++; seen = 0;
      end
      if (done) begin ncmd = 0; nwr = 0; t0_ok = 0; end
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 100000) begin
    chk(0, "watchdog", cyc, 100000);
    finish_run();
  end

  task automatic pulse_go();
    @(negedge clk); go = 1'b1;
    @(negedge clk); go = 1'b0;
  endtask

  task automatic wait_done(output int t);
    t = 0;
    while (!done && t < 20000) begin @(negedge clk); t++; end
    chk(done, "R10 done reached", done, 1);
  endtask

  task automatic after_done(input string req, input bit exp_err, input logic [15:0] er, input logic [15:0] ei);
    chk(error == exp_err, {req, " error flag"}, error, exp_err);
    chk(res_real == er, {req, " res_real"}, res_real, er);
    chk(res_imag == ei, {req, " res_imag"}, res_imag, ei);
    @(negedge clk);
    chk(!done, "R10 done one cycle", done, 0);
    repeat (12) @(negedge clk);
    chk(expq.size() == 0, {req, " stream complete"}, expq.size(), 0);
  endtask

  initial begin
    int t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk(!done && !error && !cmd_valid && res_real == 0 && res_imag == 0,
        "R10 reset state", {done, error, cmd_valid}, 0);

    // normal measurement, back-pressure, three polls
    bp = 1; freq_code = 24'h0F5C28; settle_cnt = 9'h1A5; settle_mult = 2'b01;
    exc_range = 2'b01; gain1 = 1'b1; dwell_cycles = 16'd5; exp_dwell = 5;
    exp_setup(); exp_sweep(); exp_poll(); exp_poll(); exp_poll(); exp_fetch();
    rdq = '{8'h00, 8'h04, 8'h02, 8'h12, 8'h34, 8'hFE, 8'hDC};
    pulse_go(); wait_done(t);
    chk($signed(res_imag) == -16'sd292, "R8 signed imaginary", res_imag, 16'hFEDC);
    after_done("R8 normal", 0, 16'h1234, 16'hFEDC);

    // reserved multiplier
    bp = 0; settle_mult = 2'b10;
    pulse_go(); wait_done(t);
    chk(t == 0, "R1 immediate done", t, 0);
    after_done("R1 reserved mult", 1, 16'h1234, 16'hFEDC);

    // poll limit
    settle_mult = 2'b11; exc_range = 2'b10; gain1 = 1'b0; dwell_cycles = 16'd2; exp_dwell = 2;
    exp_setup(); exp_sweep(); exp_poll(); exp_poll(); exp_poll(); exp_poll();
    rdq = '{8'h00, 8'h04, 8'h00, 8'h04};
    pulse_go(); wait_done(t);
    after_done("R7 poll limit", 1, 16'h1234, 16'hFEDC);

    // nack on the register byte of the frequency write
    bp = 1; nack_at = 4; settle_mult = 2'b00;
    exp_setup();
    pulse_go(); wait_done(t);
    after_done("R9 nack abort", 1, 16'h1234, 16'hFEDC);
    nack_at = -1;

    // busy go ignored, inputs changed mid-run, error cleared
    bp = 0; freq_code = 24'hA5C3E1; settle_cnt = 9'h0FF; settle_mult = 2'b11;
    exc_range = 2'b11; gain1 = 1'b1; dwell_cycles = 16'd0; exp_dwell = 0;
    exp_setup(); exp_sweep(); exp_poll(); exp_fetch();
    rdq = '{8'h06, 8'h80, 8'h00, 8'h7F, 8'hFF};
    pulse_go();
    repeat (30) @(negedge clk);
    freq_code = 24'h111111; settle_mult = 2'b00; exc_range = 2'b00; gain1 = 1'b0;
    go = 1'b1; @(negedge clk); go = 1'b0;
    wait_done(t);
    after_done("R11 busy go / R10 error clear", 0, 16'h8000, 16'h7FFF);

    finish_run();
  end

endmodule